// File: doc/BRIEF.md
# Rotating-Priority N:1 Request Arbiter

The block picks one of `NUM_REQ` requesters each cycle and presents the winner downstream through a valid/ready handshake. It outputs a one-hot grant, the binary number of the winning port, a valid flag and, when enabled, the data word of that port. A priority mask rotates after every completed transfer, so the port just above the last winner is served first. The lowest-numbered requester is found by a log-depth parallel-prefix OR network rather than a ripple chain.

If the sink stalls (valid high, ready low), the block keeps the same winner, index and data on the following cycles until the transfer completes. This matches what common bus protocols require. Requesters are expected to keep their request asserted until it is granted. A check-enable input switches the bench-side protocol checks on and off and has no functional effect. A parameter removes the data path entirely.

Top module: `rr_prefix_arbiter`

## Requirements
- R1: `gnt` has at most one bit set, and it is all zeros exactly when `req` is all zeros.
- R2: `idx` equals the bit position of the set bit of `gnt`, and is 0 when no request is present.
- R3: `valid` is high in a cycle exactly when at least one bit of `req` is high; a transfer completes in a cycle where `valid` and `ready` are both high.
- R4: After synchronous active-low reset, the priority state is cleared, so the lowest-numbered active request wins (port 0 highest).
- R5: After a transfer by port w completes, the next winner is the lowest-numbered active port above w; if no port above w is requesting, the winner is the lowest-numbered active port.
- R6: While `valid` is high and `ready` is low, the next cycle grants the same port (given that it keeps requesting), whatever other requests appear or disappear.
- R7: With `DATA_EN`=1, `data_out` equals word `idx` of `data_in` (word k occupies bits k*DATA_W to k*DATA_W+DATA_W-1) when `valid` is high, and is 0 when idle; with `DATA_EN`=0, `data_out` is always 0 whatever `data_in` holds.
- R8: `chk_en` has no effect on `gnt`, `idx`, `valid` or `data_out`.
- R9: Cycles without any request leave the priority state unchanged, so rotation resumes from the last winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_en | input | 1 | Enables protocol assertions only; no functional effect |
| req | input | NUM_REQ | Request line per port |
| data_in | input | NUM_REQ*DATA_W | Packed data words, word k for port k |
| ready | input | 1 | Sink accepts the presented word |
| gnt | output | NUM_REQ | One-hot grant of the winner |
| idx | output | IDX_W | Binary number of the winner |
| valid | output | 1 | At least one request is present |
| data_out | output | DATA_W | Data word of the winner |

## Verification
The only state is the priority mask, and a wrong mask shows at the ports in the same cycle it is used. A bad update after a completed transfer makes the wrong port win on the next cycle that has competing requests. A bad update during a stall makes the grant move to another port one cycle after `ready` is low. A corrupted reset or idle update shows on the first contended cycle afterwards. The bench therefore compares every cycle against a rotating-pointer model, under a sweep of all request vectors at every pointer position plus a long pseudo-random run with stalls. This catches any mask error within one cycle of its first contended use.

// File: rtl/rrpa_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the rotating-priority arbiter.
// Assumes callers pass a port count of at least 2.
package rrpa_pkg;

    // Action applied to the priority mask at the next clock edge.
    typedef enum logic [1:0] {
        MASK_KEEP    = 2'd0,  // no request: priority state untouched
        MASK_HOLD    = 2'd1,  // stalled: pin the current winner
        MASK_ADVANCE = 2'd2   // transfer done: favour ports above winner
    } mask_op_e;

    // Width of a binary port number for n ports (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rrpa_prefix_or.sv
`timescale 1ns/1ps
// Module: rrpa_prefix_or
// Computes an inclusive prefix OR from bit 0 upward: out[i] = |in[i:0].
// Built as a log2(N)-level doubling network, so depth grows with log N.
// Assumes N >= 2.
module rrpa_prefix_or #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] vec_in,
    output logic [N-1:0] prefix_out
);
    localparam int unsigned LEVELS = $clog2(N);

    // One doubling stage per level: each bit ORs in the bit 2^l below it.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        logic [N-1:0] lin;
        logic [N-1:0] lout;
        if (l == 0) begin : g_first
            assign lin = vec_in;
        end else begin : g_next
            assign lin = g_lvl[l-1].lout;
        end
        assign lout = lin | (lin << (1 << l));
    end

    assign prefix_out = g_lvl[LEVELS-1].lout;

endmodule

// File: rtl/rrpa_prio_state.sv
`timescale 1ns/1ps
// Module: rrpa_prio_state
// Holds the rotating priority mask. After a completed transfer the mask
// covers ports strictly above the winner; during a stall it covers the
// winner and everything above, which pins the winner while its request
// stays high. Idle cycles keep the mask. Synchronous active-low reset
// clears it. Assumes N >= 2.
module rrpa_prio_state
    import rrpa_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic         ready_in,
    input  logic [N-1:0] prefix_in,
    output logic [N-1:0] mask_out
);
    mask_op_e     op;
    logic [N-1:0] mask_d;
    logic [N-1:0] mask_q;

    // Decide the mask action from the handshake state.
    always_comb begin
        if (!valid_in)     op = MASK_KEEP;
        else if (ready_in) op = MASK_ADVANCE;
        else               op = MASK_HOLD;
    end

    // Form the next mask from the winner's prefix vector.
    always_comb begin
        unique case (op)
            MASK_ADVANCE: mask_d = {prefix_in[N-2:0], 1'b0};
            MASK_HOLD:    mask_d = prefix_in;
            default:      mask_d = mask_q;
        endcase
    end

    // Register the mask with synchronous reset to "no masked priority".
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_out = mask_q;

endmodule

// File: rtl/rrpa_onehot_enc.sv
`timescale 1ns/1ps
// Module: rrpa_onehot_enc
// Converts a one-hot (or zero) vector into its binary bit position.
// Output is 0 for an all-zero input. Assumes at most one bit is set.
module rrpa_onehot_enc #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     onehot_in,
    output logic [IDX_W-1:0] idx_out
);
    // OR together the numbers of all set positions (one at most).
    always_comb begin
        idx_out = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_in[i]) idx_out = idx_out | IDX_W'(i);
        end
    end

endmodule

// File: rtl/rrpa_data_sel.sv
`timescale 1ns/1ps
// Module: rrpa_data_sel
// AND-OR selection of the granted data word. When EN is 0 the path is
// removed and the output is a constant zero. Assumes a one-hot grant.
module rrpa_data_sel #(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 32,
    parameter bit          EN = 1'b1
) (
    input  logic [N-1:0]    gnt_in,
    input  logic [N*DW-1:0] data_in,
    output logic [DW-1:0]   data_out
);
    if (EN) begin : g_route
        // Gate each word by its grant bit and merge.
        always_comb begin
            data_out = '0;
            for (int i = 0; i < N; i++) begin
                data_out = data_out | ({DW{gnt_in[i]}} & data_in[i*DW +: DW]);
            end
        end
    end else begin : g_off
        logic unused_sel;
        assign unused_sel = ^{gnt_in, data_in};
        assign data_out   = '0;
    end

endmodule

// File: rtl/rr_prefix_arbiter.sv
`timescale 1ns/1ps
// Module: rr_prefix_arbiter (top)
// N:1 rotating-priority arbiter with a valid/ready output. Requests inside
// the priority mask are searched first; if none, all requests are searched.
// The lowest set bit of the chosen vector wins, found through a prefix-OR
// network. The winner is held across stalls through the mask.
// Assumes NUM_REQ >= 2 and that requesters hold a request until granted.
module rr_prefix_arbiter
    import rrpa_pkg::*;
#(
    parameter int unsigned NUM_REQ = 8,
    parameter int unsigned DATA_W  = 32,
    parameter bit          DATA_EN = 1'b1,
    localparam int unsigned IDX_W  = idx_width(NUM_REQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      chk_en,
    input  logic [NUM_REQ-1:0]        req,
    input  logic [NUM_REQ*DATA_W-1:0] data_in,
    input  logic                      ready,
    output logic [NUM_REQ-1:0]        gnt,
    output logic [IDX_W-1:0]          idx,
    output logic                      valid,
    output logic [DATA_W-1:0]         data_out
);
    logic [NUM_REQ-1:0] mask;
    logic [NUM_REQ-1:0] masked_req;
    logic [NUM_REQ-1:0] search_vec;
    logic [NUM_REQ-1:0] prefix;
    logic               unused_chk;

    // chk_en only gates the bound checker.
    assign unused_chk = chk_en;

    // Pick the masked requests if any exist, else the full request set.
    always_comb begin
        masked_req = req & mask;
        search_vec = (|masked_req) ? masked_req : req;
    end

    rrpa_prefix_or #(
        .N (NUM_REQ)
    ) u_prefix (
        .vec_in     (search_vec),
        .prefix_out (prefix)
    );

    // Lowest set bit is where the prefix first turns on.
    always_comb begin
        gnt   = prefix & ~{prefix[NUM_REQ-2:0], 1'b0};
        valid = prefix[NUM_REQ-1];
    end

    rrpa_prio_state #(
        .N (NUM_REQ)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid),
        .ready_in  (ready),
        .prefix_in (prefix),
        .mask_out  (mask)
    );

    rrpa_onehot_enc #(
        .N     (NUM_REQ),
        .IDX_W (IDX_W)
    ) u_enc (
        .onehot_in (gnt),
        .idx_out   (idx)
    );

    rrpa_data_sel #(
        .N  (NUM_REQ),
        .DW (DATA_W),
        .EN (DATA_EN)
    ) u_data (
        .gnt_in   (gnt),
        .data_in  (data_in),
        .data_out (data_out)
    );

endmodule

// File: rtl/rrpa_checker.sv
`timescale 1ns/1ps
// Module: rrpa_checker
// Port-level protocol checks for rr_prefix_arbiter, bound to every
// instance. Stall-related checks are gated by chk_en.
module rrpa_checker #(
    parameter int unsigned NUM_REQ = 8,
    parameter int unsigned DATA_W  = 32,
    parameter bit          DATA_EN = 1'b1,
    parameter int unsigned IDX_W   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      chk_en,
    input logic [NUM_REQ-1:0]        req,
    input logic [NUM_REQ*DATA_W-1:0] data_in,
    input logic                      ready,
    input logic [NUM_REQ-1:0]        gnt,
    input logic [IDX_W-1:0]          idx,
    input logic                      valid,
    input logic [DATA_W-1:0]         data_out
);
    // R1: grant never has more than one bit.
    p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R1, R3: grant and valid appear exactly when requests do.
    p_valid_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid == (|req)) && ((gnt != '0) == (|req)));

    // R2: index points at the granted bit.
    p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> gnt[idx]);

    // R2: idle index is zero.
    p_idx_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (idx == '0));

    // R6: a stalled winner is kept on the next cycle.
    p_hold_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && valid && !ready) |=> (gnt == $past(gnt)));

    // R6: requesters keep the stalled request asserted.
    p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && valid && !ready) |=> ((req & $past(gnt)) != '0));

    // R7: data follows the grant, or is zero when the path is disabled.
    p_data_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (data_out == (DATA_EN ? data_in[int'(idx)*DATA_W +: DATA_W]
                                        : '0)));

endmodule

bind rr_prefix_arbiter rrpa_checker #(
    .NUM_REQ (NUM_REQ),
    .DATA_W  (DATA_W),
    .DATA_EN (DATA_EN),
    .IDX_W   (IDX_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (chk_en),
    .req      (req),
    .data_in  (data_in),
    .ready    (ready),
    .gnt      (gnt),
    .idx      (idx),
    .valid    (valid),
    .data_out (data_out)
);

// File: tb/rr_prefix_arbiter_tb.sv
`timescale 1ns/1ps
// Bench: two arbiters (data path on / off, chk_en inverted on the second)
// compared every cycle against a rotating-pointer model.
module rr_prefix_arbiter_tb;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_en = 1'b1;
    logic          ready = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*DW-1:0] din = '0;
    logic [N-1:0]  gnt, gnt_b;
    logic [IW-1:0] idx, idx_b;
    logic          valid, valid_b;
    logic [DW-1:0] dout, dout_b;

    always #2 clk = ~clk;

    rr_prefix_arbiter #(.NUM_REQ(N), .DATA_W(DW), .DATA_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .req(req), .data_in(din),
        .ready(ready), .gnt(gnt), .idx(idx), .valid(valid), .data_out(dout));

    rr_prefix_arbiter #(.NUM_REQ(N), .DATA_W(DW), .DATA_EN(1'b0)) u_dut_nodata (
        .clk(clk), .rst_n(rst_n), .chk_en(~chk_en), .req(req), .data_in(din),
        .ready(ready), .gnt(gnt_b), .idx(idx_b), .valid(valid_b), .data_out(dout_b));

    int n_checks = 0;
    int n_fail   = 0;
    int base     = 0;
    int hold     = -1;
    logic [31:0] lfsr = 32'h1234_5679;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int pick(input logic [N-1:0] r);
        if (hold >= 0 && r[hold]) return hold;
        for (int i = base; i < N; i++) if (r[i]) return i;
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    task automatic rnd();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
    endtask

    // One cycle: drive, check combinational outputs, advance model.
    task automatic step(input logic [N-1:0] r, input bit rdy, input bit ce,
                        input string tag);
        int w;
        logic [N-1:0]  eg;
        logic [IW-1:0] ei;
        logic [DW-1:0] ed;
        string gtag;
        @(negedge clk);
        if (hold >= 0) r[hold] = 1'b1;
        rnd();
        req = r; ready = rdy; chk_en = ce; din = lfsr[N*DW-1:0];
        #1;
        w  = pick(r);
        eg = (w >= 0) ? (N'(1) << w) : '0;
        ei = (w >= 0) ? IW'(w) : '0;
        ed = (w >= 0) ? din[w*DW +: DW] : '0;
        gtag = (tag != "") ? tag : ((hold >= 0) ? "R6 held grant" : "R5 grant");
        chk(gnt == eg, gtag, 64'(gnt), 64'(eg));
        chk($onehot0(gnt), "R1 onehot grant", 64'(gnt), 64'(eg));
        chk(idx == ei, "R2 index", 64'(idx), 64'(ei));
        chk(valid == (w >= 0), "R3 valid", 64'(valid), 64'(w >= 0));
        chk(dout == ed, "R7 data routed", 64'(dout), 64'(ed));
        chk(dout_b == '0, "R7 data disabled is zero", 64'(dout_b), 64'd0);
        chk({gnt_b, idx_b, valid_b} == {gnt, idx, valid}, "R8 chk_en no effect",
            64'({gnt_b, idx_b, valid_b}), 64'({gnt, idx, valid}));
        if (w >= 0) begin
            if (rdy) begin base = w + 1; hold = -1; end
            else hold = w;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        base = 0; hold = -1;
    endtask

    initial begin
        #(64'd800000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // Reset state at the ports: idle outputs.
        #1;
        chk(gnt == '0, "R1 reset grant zero", 64'(gnt), 64'd0);
        chk(idx == '0, "R2 reset index zero", 64'(idx), 64'd0);
        chk(valid == 1'b0, "R3 reset valid low", 64'(valid), 64'd0);
        step(4'b1111, 1'b1, 1'b1, "R4 port 0 first after reset");
        // Move priority away from 0, then reset mid-run.
        step(4'b0100, 1'b1, 1'b1, "");
        do_reset();
        step(4'b1110, 1'b1, 1'b1, "R4 lowest wins after reset");
        // R9: idle cycles keep rotation (winner 1, then idle, then port 2).
        do_reset();
        step(4'b0010, 1'b1, 1'b1, "");
        for (int k = 0; k < 3; k++) step(4'b0000, 1'b1, 1'b0, "");
        step(4'b1111, 1'b1, 1'b1, "R9 idle keeps priority");
        // R6 directed: stall on port 2 while others come and go.
        do_reset();
        step(4'b0100, 1'b0, 1'b1, "");
        step(4'b0011, 1'b0, 1'b1, "R6 stall keeps port 2");
        step(4'b1001, 1'b1, 1'b0, "R6 stall keeps port 2");
        step(4'b1011, 1'b1, 1'b1, "R5 above last winner");
        // Sweep: every request vector at every pointer position.
        do_reset();
        for (int v = 0; v < (1 << N); v++)
            for (int k = 0; k <= N; k++)
                step(N'(v), 1'b1, k[0], "");
        // Pseudo-random run with stalls and idle cycles.
        for (int c = 0; c < 3000; c++) begin
            rnd();
            step(lfsr[N-1:0] & lfsr[N+3:4], lfsr[9] | lfsr[10], lfsr[11], "");
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule